// File: doc/BRIEF.md
# Serial Clock-Synthesizer Configuration Master

This block sets up an external clock synthesizer whose configuration is loaded over three wires: a serial clock, a data line and a latch strobe. A request brings three values: a reference divider word, a feedback divider word for the oscillator loop, and an output divide ratio. The block first checks that the values are legal. It turns the divide ratio into its 3-bit code and builds a 24-bit control word. It sends that word most significant bit first and then raises the strobe for one serial period. The synthesizer takes the word when the strobe falls.

A request that is not legal is refused: the block raises a one-cycle error flag and sends nothing. At the end of a frame the block raises a one-cycle done flag, lowers busy and copies the word just sent into a readable shadow register. From reset the shadow register holds the word the synthesizer has at power-up. Requests that arrive while a frame is in progress are ignored.

Top module: `synth_cfg_master`

## Requirements
- R1: During and just after reset the outputs are as follows. `sclk`, `sdata`, `slatch`, `busy`, `done` and `err` are 0, and `shadow_word` is 24'h230406.
- R2: The control word is built as follows. Bits 23..19 are the parameter `UPPER_FIELD` (default 5'b00100). Bits 18..16 are the divide code. Bits 15..7 are `cfg_vdw` and bits 6..0 are `cfg_rdw`. The bits go out on `sdata` starting with bit 23 and ending with bit 0.
- R3: The divide ratio maps to a 3-bit code. Ratio 2 gives 001, 3 gives 110, 4 gives 011, 5 gives 100, 6 gives 111, 7 gives 101, 8 gives 010 and 10 gives 000.
- R4: A request is illegal when its ratio is not one of those eight, when `cfg_vdw` is below 4, or when `cfg_rdw` is 0. An illegal request raises `err` for exactly the one cycle after it is sampled. It starts no frame, leaves `busy` low and leaves `shadow_word` unchanged.
- R5: Each bit lasts one serial period of 2×`HALF_DIV` system cycles. During the first half `sclk` is low and during the second half it is high. `sdata` changes only at the start of a period, so it is stable while `sclk` is high.
- R6: Outside the bit periods of a frame, `sclk` stays low. Whenever no frame is in progress, `sdata` is also low.
- R7: After the falling edge that ends bit 0, `slatch` is high for 2×`HALF_DIV` cycles. During that time `sclk` and `sdata` are low.
- R8: In the cycle where `slatch` falls, `done` is high for one cycle, `busy` drops, and `shadow_word` takes the word just sent. `shadow_word` changes at no other time.
- R9: A request seen while `busy` is high has no effect on the frame in progress or on `shadow_word`.
- R10: If a request is present in the cycle where `done` is high, it is accepted at the next edge, and a new frame starts with no idle gap.
- R11: `busy` rises in the cycle after a legal request is sampled and stays high for exactly 50×`HALF_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Request present; sampled while idle |
| cfg_od | input | 4 | Output divide ratio (2..8 or 10) |
| cfg_vdw | input | 9 | Feedback divider word, 4..511 |
| cfg_rdw | input | 7 | Reference divider word, 1..127 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the word is latched |
| err | output | 1 | One-cycle pulse for a refused request |
| sclk | output | 1 | Serial clock to the synthesizer |
| sdata | output | 1 | Serial data to the synthesizer |
| slatch | output | 1 | Latch strobe; the word is taken on its falling edge |
| shadow_word | output | 24 | Last word latched, or the power-up word |

## Verification
The end of one frame and the acceptance of the next can fall in the same cycle. `done` is high in the first idle cycle, so a request already waiting there is sampled at the very next edge. The bench provokes this by holding `cfg_valid` high across a whole frame. The cycle model then expects `done`, and one edge later `busy` and the first bit period, with no idle cycle between them. Stray single-cycle requests in the middle of a frame check the other side of the same rule: the model predicts an unchanged waveform and an unchanged shadow word.

// File: rtl/synth_cfg_master.sv
module synth_cfg_master #(
  parameter int          HALF_DIV    = 2,
  parameter logic [4:0]  UPPER_FIELD = 5'b00100,
  parameter logic [23:0] RESET_WORD  = 24'h230406
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic [3:0]  cfg_od,
  input  logic [8:0]  cfg_vdw,
  input  logic [6:0]  cfg_rdw,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        sclk,
  output logic        sdata,
  output logic        slatch,
  output logic [23:0] shadow_word
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LATCH} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [4:0]       bitn;
  logic [23:0]      sreg, word_q;
  logic             second_half;
  logic [2:0]       od_code;
  logic             od_ok;

  always_comb begin
    od_ok   = 1'b1;
    od_code = 3'b000;
    case (cfg_od)
      4'd10:   od_code = 3'b000;
      4'd2:    od_code = 3'b001;
      4'd8:    od_code = 3'b010;
      4'd4:    od_code = 3'b011;
      4'd5:    od_code = 3'b100;
      4'd7:    od_code = 3'b101;
      4'd3:    od_code = 3'b110;
      4'd6:    od_code = 3'b111;
      default: od_ok   = 1'b0;
    endcase
  end

  wire        legal   = od_ok && (cfg_vdw >= 9'd4) && (cfg_rdw != 7'd0);
  wire [23:0] new_word = {UPPER_FIELD, od_code, cfg_vdw, cfg_rdw};
  wire        tick     = (cnt == CNT_LAST);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      bitn        <= '0;
      sreg        <= '0;
      word_q      <= '0;
      second_half <= 1'b0;
      sclk        <= 1'b0;
      sdata       <= 1'b0;
      slatch      <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      shadow_word <= RESET_WORD;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cfg_valid) begin
            if (legal) begin
              state  <= S_SHIFT;
              sreg   <= new_word;
              word_q <= new_word;
              sdata  <= new_word[23];
              cnt    <= '0;
              bitn   <= '0;
              sclk   <= 1'b0;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_SHIFT: begin
          if (tick) begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitn == 5'd23) begin
                state       <= S_LATCH;
                slatch      <= 1'b1;
                sdata       <= 1'b0;
                second_half <= 1'b0;
              end else begin
                bitn  <= bitn + 5'd1;
                sreg  <= {sreg[22:0], 1'b0};
                sdata <= sreg[22];
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LATCH: begin
          if (tick) begin
            cnt <= '0;
            if (!second_half) begin
              second_half <= 1'b1;
            end else begin
              slatch      <= 1'b0;
              done        <= 1'b1;
              shadow_word <= word_q;
              state       <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/synth_cfg_master_chk.sv
module synth_cfg_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        sclk,
  input logic        sdata,
  input logic        slatch,
  input logic [23:0] shadow_word
);

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !slatch && !sdata)); // R6

  AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    slatch |-> (!sclk && !sdata)); // R7

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata)); // R5

  AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $fell(slatch))); // R8

  AST_ERR_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !$past(busy))); // R4

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err})); // R8

  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(shadow_word)); // R8

endmodule

bind synth_cfg_master synth_cfg_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .sclk(sclk), .sdata(sdata), .slatch(slatch), .shadow_word(shadow_word)
);

// File: tb/synth_cfg_master_tb_top.sv
module synth_cfg_master_tb_top;
  localparam int CLK_P = 10;
  localparam int H     = 2;
  localparam int FRAME = 50 * H;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [3:0]  cfg_od = '0;
  logic [8:0]  cfg_vdw = '0;
  logic [6:0]  cfg_rdw = '0;
  logic        busy, done, err, sclk, sdata, slatch;
  logic [23:0] shadow_word;

  synth_cfg_master #(.HALF_DIV(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_od(cfg_od),
    .cfg_vdw(cfg_vdw), .cfg_rdw(cfg_rdw), .busy(busy), .done(done), .err(err),
    .sclk(sclk), .sdata(sdata), .slatch(slatch), .shadow_word(shadow_word)
  );

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit started = 0, finished = 0;
  string phase = "R1";

  int          ratio_of [8] = '{10, 2, 8, 4, 5, 7, 3, 6};
  int          mj = -1;
  logic [23:0] mw = '0, mshadow = 24'h230406;
  bit          mdone = 0, merr = 0;

  function automatic int code_of(input int od);
    for (int c = 0; c < 8; c++) if (ratio_of[c] == od) return c;
    return -1;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mj = -1; mdone = 0; merr = 0; mshadow = 24'h230406;
    end else begin
      bit idle;
      int c;
      idle = (mj < 0);
      mdone = 0; merr = 0;
      if (!idle) begin
        mj++;
        if (mj == FRAME) begin mj = -1; mdone = 1; mshadow = mw; end
      end else if (cfg_valid) begin
        c = code_of(int'(cfg_od));
        if (c >= 0 && cfg_vdw >= 4 && cfg_rdw != 0) begin
          mw = {5'b00100, 3'(c), cfg_vdw, cfg_rdw};
          mj = 0;
        end else merr = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp_v);
    if (act !== exp_v) begin
      miscompares++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", tag, phase, $time, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      logic e_busy, e_clk, e_data, e_latch;
      e_busy = 0; e_clk = 0; e_data = 0; e_latch = 0;
      if (mj >= 0) begin
        e_busy = 1;
        if (mj < 48 * H) begin
          e_clk  = (mj % (2 * H)) >= H;
          e_data = mw[23 - mj / (2 * H)];
        end else e_latch = 1;
      end
      vectors++;
      chk("R11 busy",   24'(busy),   24'(e_busy));
      chk("R5 sclk",    24'(sclk),   24'(e_clk));
      chk("R2 sdata",   24'(sdata),  24'(e_data));
      chk("R7 slatch",  24'(slatch), 24'(e_latch));
      chk("R8 done",    24'(done),   24'(mdone));
      chk("R4 err",     24'(err),    24'(merr));
      chk("R8 shadow",  shadow_word, mshadow);
    end
  end

  task automatic req(input int od, input int vdw, input int rdw);
    @(negedge clk);
    cfg_valid = 1; cfg_od = 4'(od); cfg_vdw = 9'(vdw); cfg_rdw = 7'(rdw);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic settle();
    repeat (FRAME + 4) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    report();
  end

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    phase = "R2";   req(10, 4, 1);    settle();
    phase = "R2";   req(6, 511, 127); settle();
    phase = "R3";
    for (int c = 0; c < 8; c++) begin req(ratio_of[c], 100 + c, 5 + c); settle(); end
    phase = "R4";
    req(9, 50, 3);  repeat (3) @(negedge clk);
    req(1, 50, 3);  repeat (3) @(negedge clk);
    req(0, 50, 3);  repeat (3) @(negedge clk);
    req(11, 50, 3); repeat (3) @(negedge clk);
    req(15, 50, 3); repeat (3) @(negedge clk);
    req(4, 3, 3);   repeat (3) @(negedge clk);
    req(4, 0, 3);   repeat (3) @(negedge clk);
    req(4, 50, 0);  repeat (3) @(negedge clk);
    phase = "R6";   repeat (5) @(negedge clk);
    phase = "R9";
    req(5, 300, 20);
    repeat (10) @(negedge clk);
    req(7, 77, 7);
    repeat (40) @(negedge clk);
    req(9, 0, 0);
    settle();
    phase = "R10";
    @(negedge clk);
    cfg_valid = 1; cfg_od = 4'd8; cfg_vdw = 9'd200; cfg_rdw = 7'd64;
    repeat (FRAME + 1) @(negedge clk);
    cfg_od = 4'd3; cfg_vdw = 9'd9; cfg_rdw = 7'd2;
    repeat (FRAME + 3) @(negedge clk);
    cfg_valid = 0;
    settle();
    phase = "R7";   req(2, 256, 64); settle();
    report();
  end
endmodule